// File: doc/BRIEF.md
# Flash Completion Status Poller

This block decides when a parallel NOR flash has finished an internal program or erase operation. After a start pulse it reads one address of the flash again and again through a plain asynchronous read port. For each read it drives chip-enable and output-enable low for a fixed number of clocks, then captures the data bus. It judges completion by one of two status-bit rules and stops early if the number of polls runs out.

In toggle mode the device flips one status bit on every read while it is busy. The poller takes one reference read first. It then compares each new read with the one before it, and the newest read always becomes the reference. In data-polling mode the device shows the complement of the written data's top bit while busy. The poller compares that bit of each read with the same bit of an expected byte it was given. Both modes share one bounded loop. The loop ends with a single-cycle done pulse, and a flag on that pulse shows whether the limit was reached.

Top module: `flash_done_poller`

## Requirements
- R1: After reset the block is idle: `busy`, `donePulse` and `timedOut` are 0, and `flashCeN` and `flashOeN` are 1.
- R2: Every read holds `flashCeN` and `flashOeN` low together for exactly `ACCESS_CLKS` consecutive clocks. `flashAddr` equals the address latched at start for every read of that poll.
- R3: With `modeSel` = 0 (toggle mode), only bit 6 of each read (mask 0x40) is compared. The poll completes when a read's bit 6 equals that of the read just before it. Otherwise the newest read becomes the reference. All other data bits have no effect.
- R4: Toggle mode first takes one reference read that is not counted, so a toggle poll that completes after N comparisons makes N+1 reads.
- R5: With `modeSel` = 1 (data-polling mode), bit 7 of each read (mask 0x80) is compared with bit 7 of `expData`. The poll completes on the first equal read, and all other bits of both values have no effect.
- R6: After `MAX_ITER` comparison reads without completion the poll ends with `timedOut` = 1. A completion on the `MAX_ITER`-th comparison read ends with `timedOut` = 0.
- R7: Each poll ends with `donePulse` high for exactly one cycle. `timedOut` is only ever high together with `donePulse`, and `busy` is already low in that cycle.
- R8: A start request while `busy` is high is ignored: the mode, address and read count of the running poll do not change. The comparison count starts from zero on every accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, accepted only when idle |
| modeSel | input | 1 | 0 = toggle mode, 1 = data-polling mode |
| pollAddr | input | ADDR_W | Flash address to poll |
| expData | input | DATA_W | Expected byte for data-polling mode |
| flashAddr | output | ADDR_W | Flash read address |
| flashCeN | output | 1 | Flash chip-enable, active low |
| flashOeN | output | 1 | Flash output-enable, active low |
| flashData | input | DATA_W | Flash read data |
| busy | output | 1 | Poll in progress |
| donePulse | output | 1 | One-cycle end-of-poll pulse |
| timedOut | output | 1 | With donePulse: the limit was reached |

## Verification
A behavioural flash model drives status bits that change per read, with noise on every other data bit. In toggle mode it stops flipping bit 6 after a chosen number of reads. Stopping at once, after a few reads, exactly at the limit and never separates the reference read, the comparison of neighbouring reads and the timeout boundary. In data-polling mode it holds bit 7 inverted for a chosen number of reads, against expected bytes with bit 7 set and clear. This shows that only bit 7 matters and that the limit is applied to the exact read. A second start during a running poll, and a poll run right after a timeout, separate ignored starts and counter clearing from a stuck configuration.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic {
    MODE_TOGGLE = 1'b0,
    MODE_DPOLL  = 1'b1
  } pollMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchCfg;  // take address, mode, expected byte
    logic capture;   // sample the flash data bus
    logic loadRef;   // newest capture becomes reference
  } pollStrb_t;

  localparam int TOGGLE_BIT = 6;
  localparam int POLL_BIT   = 7;

endpackage

// File: rtl/flash_poll_datapath.sv
module flash_poll_datapath
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrb_t         strb,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [DATA_W-1:0] expData,
  input  logic [DATA_W-1:0] flashData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              match
);

  localparam logic [DATA_W-1:0] TOG_MASK  = DATA_W'(1) << TOGGLE_BIT;
  localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << POLL_BIT;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] expQ;
  logic [DATA_W-1:0] capQ;
  logic [DATA_W-1:0] refQ;
  pollMode_t         modeQ;
  logic [DATA_W-1:0] bitMask;

  assign bitMask = (modeQ == MODE_TOGGLE) ? TOG_MASK : POLL_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      expQ  <= '0;
      modeQ <= MODE_TOGGLE;
    end else if (strb.latchCfg) begin
      addrQ <= pollAddr;
      expQ  <= expData & POLL_MASK;
      modeQ <= pollMode_t'(modeSel);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capQ <= '0;
      refQ <= '0;
    end else begin
      if (strb.capture) capQ <= flashData & bitMask;
      if (strb.loadRef) refQ <= capQ;
    end
  end

  assign match = (modeQ == MODE_TOGGLE) ? (capQ == refQ) : (capQ == expQ);
  assign flashAddr = addrQ;

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchCfg |=> $stable(addrQ) && $stable(modeQ) && $stable(expQ));

  // R3
  toggle_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_TOGGLE) && $past(strb.capture) && !$past(strb.latchCfg)
      |-> (capQ & ~TOG_MASK) == '0);

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int ACCESS_CLKS = 3,
  parameter int MAX_ITER    = 32'h0FFF_FFFF
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      modeSel,
  input  logic      match,
  output pollStrb_t strb,
  output logic      readOn,
  output logic      busy,
  output logic      donePulse,
  output logic      timedOut
);

  localparam int TMR_W = $clog2(ACCESS_CLKS + 1);
  localparam int CNT_W = $clog2(MAX_ITER + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(ACCESS_CLKS - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_ITER - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_EVAL} state_t;

  state_t          state;
  logic [TMR_W-1:0] timer;
  logic [CNT_W-1:0] iterCnt;
  logic            firstRd;
  logic            doneQ;
  logic            toutQ;

  assign busy      = (state != ST_IDLE);
  assign readOn    = (state == ST_READ);
  assign donePulse = doneQ;
  assign timedOut  = toutQ;

  always_comb begin
    strb          = '0;
    strb.latchCfg = (state == ST_IDLE) && startReq;
    strb.capture  = (state == ST_READ) && (timer == TMR_LAST);
    strb.loadRef  = (state == ST_EVAL) && (firstRd || !match);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      iterCnt <= '0;
      firstRd <= 1'b0;
      doneQ   <= 1'b0;
      toutQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      toutQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_READ;
            timer   <= '0;
            iterCnt <= '0;
            firstRd <= (pollMode_t'(modeSel) == MODE_TOGGLE);
          end
        end
        ST_READ: begin
          if (timer == TMR_LAST) state <= ST_EVAL;
          else                   timer <= timer + 1'b1;
        end
        ST_EVAL: begin
          if (firstRd) begin
            firstRd <= 1'b0;
            timer   <= '0;
            state   <= ST_READ;
          end else if (match) begin
            doneQ <= 1'b1;
            state <= ST_IDLE;
          end else if (iterCnt == CNT_LAST) begin
            doneQ <= 1'b1;
            toutQ <= 1'b1;
            state <= ST_IDLE;
          end else begin
            iterCnt <= iterCnt + 1'b1;
            timer   <= '0;
            state   <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R7
  tout_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> donePulse && !busy);

  // R2
  read_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readOn) |-> $past(timer) == TMR_LAST);

  // R6
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    iterCnt <= CNT_LAST);

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> !$past(strb.latchCfg));

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 8,
  parameter int ACCESS_CLKS = 3,
  parameter int MAX_ITER    = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [DATA_W-1:0] expData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashCeN,
  output logic              flashOeN,
  input  logic [DATA_W-1:0] flashData,
  output logic              busy,
  output logic              donePulse,
  output logic              timedOut
);

  pollStrb_t strb;
  logic      match;
  logic      readOn;

  flash_poll_ctrl #(
    .ACCESS_CLKS(ACCESS_CLKS),
    .MAX_ITER   (MAX_ITER)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .modeSel  (modeSel),
    .match    (match),
    .strb     (strb),
    .readOn   (readOn),
    .busy     (busy),
    .donePulse(donePulse),
    .timedOut (timedOut)
  );

  flash_poll_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .modeSel  (modeSel),
    .pollAddr (pollAddr),
    .expData  (expData),
    .flashData(flashData),
    .flashAddr(flashAddr),
    .match    (match)
  );

  assign flashCeN = !readOn;
  assign flashOeN = !readOn;

endmodule

// File: tb/sim_flash_done_poller.sv
`timescale 1ns/1ps
module sim_flash_done_poller;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int ACCESS = 3;
  localparam int MAXI   = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic modeSel = 1'b0;
  logic [ADDR_W-1:0] pollAddr = '0;
  logic [DATA_W-1:0] expData = '0;
  logic [ADDR_W-1:0] flashAddr;
  logic flashCeN, flashOeN, busy, donePulse, timedOut;
  logic [DATA_W-1:0] modelData = 8'h00;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // flash model state
  int   rdIdx = 0;
  int   settleAt = 0;
  bit   dpMode = 0;
  logic [7:0] goodByte = 8'h00;
  logic [ADDR_W-1:0] wantAddr = '0;
  int   addrErr = 0;
  int   widthErr = 0;
  int   strobeErr = 0;
  int   lowCnt = 0;

  always #2 clk = ~clk;

  flash_done_poller #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACCESS_CLKS(ACCESS), .MAX_ITER(MAXI)
  ) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeSel(modeSel),
    .pollAddr(pollAddr), .expData(expData), .flashAddr(flashAddr),
    .flashCeN(flashCeN), .flashOeN(flashOeN), .flashData(modelData),
    .busy(busy), .donePulse(donePulse), .timedOut(timedOut)
  );

  // Behavioural flash: new status per read, noise on other bits
  always @(negedge flashOeN) begin
    logic [7:0] v;
    logic par;
    if (rstN) begin
      if (flashAddr !== wantAddr) addrErr++;
      v = 8'(rdIdx * 37 + 5);
      if (!dpMode) begin
        par = (settleAt == 0) ? 1'b1 : 1'((settleAt - 1) & 1);
        v[6] = (rdIdx < settleAt) ? 1'(rdIdx & 1) : par;
      end else begin
        v[7] = (rdIdx < settleAt) ? ~goodByte[7] : goodByte[7];
      end
      modelData = v;
      rdIdx++;
    end
  end

  // strobe width and pairing monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (flashCeN !== flashOeN) strobeErr++;
      if (!flashOeN) lowCnt++;
      else begin
        if (lowCnt != 0 && lowCnt != ACCESS) widthErr++;
        lowCnt = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runPoll(input string req, input logic m, input logic [15:0] a,
                         input logic [7:0] e, input int settle, input int expReads,
                         input int expTout, input bit disturb);
    int cyc = 0;
    rdIdx = 0; settleAt = settle; dpMode = m; goodByte = e; wantAddr = a;
    @(negedge clk);
    modeSel = m; pollAddr = a; expData = e; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (!donePulse && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 5) begin
        // R8: competing start with other mode and address
        startReq = 1'b1; modeSel = ~m; pollAddr = ~a; expData = ~e;
      end else startReq = 1'b0;
    end
    startReq = 1'b0;
    chk(req, "done seen", int'(donePulse), 1);
    chk(req, "read count", rdIdx, expReads);
    chk("R6", "timeout flag", int'(timedOut), expTout);
    chk("R7", "busy low at done", int'(busy), 0);
    @(negedge clk);
    chk("R7", "done single cycle", int'(donePulse), 0);
    chk("R7", "flag low after done", int'(timedOut), 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(donePulse), 0);
    chk("R1", "timeout after reset", int'(timedOut), 0);
    chk("R1", "ce high", int'(flashCeN), 1);
    chk("R1", "oe high", int'(flashOeN), 1);
  endtask

  task automatic testToggle();
    runPoll("R3", 1'b0, 16'h1234, 8'h00, 3, 4, 0, 0);     // settles after 3 flips
    runPoll("R4", 1'b0, 16'h0040, 8'hFF, 0, 2, 0, 0);     // reference + one compare
    runPoll("R6", 1'b0, 16'hBEEF, 8'h00, 100, MAXI + 1, 1, 0); // never settles
    runPoll("R8", 1'b0, 16'h5555, 8'h00, MAXI, MAXI + 1, 0, 0); // last allowed, after timeout
  endtask

  task automatic testDataPoll();
    runPoll("R5", 1'b1, 16'h2AAA, 8'hAA, 0, 1, 0, 0);     // bit7 set, low bits differ
    runPoll("R5", 1'b1, 16'h0100, 8'h55, 2, 3, 0, 0);     // bit7 clear
    runPoll("R6", 1'b1, 16'h0101, 8'h80, MAXI - 1, MAXI, 0, 0); // match on last read
    runPoll("R6", 1'b1, 16'h7777, 8'h80, MAXI, MAXI, 1, 0);     // one read too late
  endtask

  task automatic testBusyStart();
    runPoll("R8", 1'b0, 16'h0C0C, 8'h00, 4, 5, 0, 1);
    chk("R8", "address held (mismatched reads)", addrErr, 0);
  endtask

  task automatic testStrobes();
    chk("R2", "strobe width errors", widthErr, 0);
    chk("R2", "ce/oe pairing errors", strobeErr, 0);
    chk("R2", "address errors", addrErr, 0);
  endtask

  initial begin
    testReset();
    testToggle();
    testDataPoll();
    testBusyStart();
    testStrobes();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule